// File: doc/BRIEF.md
# Stateful Crossbar Logic Sequencer

This block runs one two-input Boolean function at a time on a single bistable cell of a resistive crossbar. The cell array itself is held as a digital behavioural model. Each cell stores 1 in its low-resistance state and 0 in its high-resistance state. A request carries a cell address, a 4-bit function code and two operand bits p and q. The block assigns four control variables from that request. W is the state written during preparation. A and B are the two line levels. C is the swap control, which decides whether A goes to the word line and B to the bit line, or the reverse. The block then drives a 2-bit code on every word line and bit line through three phases and returns the bit stored in the cell.

The function code is a truth table: bit `2*p+q` of the code is the result for that operand pair. The stored result is nonvolatile. A request with the skip flag set leaves out the preparation write, so the cell's current content takes the place of W. This lets results be chained in place. The line codes are 0 ground, 1 half level, 2 write level and 3 read level. The half level is half of whatever level the selected line carries in the current phase.

The controller has four states. `PH_IDLE` goes to `PH_INIT` on an accepted start, or to `PH_LOGIC` when skip is set. `PH_INIT` goes to `PH_LOGIC` after one write pulse. `PH_LOGIC` goes to `PH_READ` after one write pulse. `PH_READ` goes back to `PH_IDLE` after the read window, and done is raised on that transition.

Top module: `xbar_logic_seq`

## Requirements
- R1: After reset the block is idle: busy, done and result are 0 and every word line and bit line code is 0 (ground).
- R2: A normal operation passes through preparation, logic write and read in that order. Each write phase lasts CLK_HZ*PULSE_NS/1e9 clocks (100 by default) and the read lasts READ_CYC clocks (4), so done rises 204 clocks after the start edge.
- R3: In preparation, W=1 drives the selected word line to code 2 and grounds the selected bit line. W=0 does the reverse. Code 0 prepares with W=0 and code 15 prepares with W=1.
- R4: In the logic write, C=1 routes A to the selected word line and B to the bit line, and C=0 swaps them; a 1 is code 2 and a 0 is code 0. Code 8 (AND) uses W=0, A=p, B=0, C=q.
- R5: A cell becomes 1 when its word line is at write level and its bit line is grounded. It becomes 0 in the opposite case. Any other pair of levels leaves it unchanged.
- R6: While busy, every unselected word line and bit line is at code 1 (half), so no unaddressed cell sees the full level; while idle all lines are at code 0.
- R7: For every function code f and operand pair (p,q), the read result equals bit 2p+q of f.
- R8: With skip set, no preparation phase runs (done after 104 clocks) and the cell's stored value acts as W. Code 0 applies equal levels on both selected lines, so a skipped code 0 returns the stored value unchanged.
- R9: During the read the selected word line is at code 3 and the selected bit line at code 0, and a stored 1 is reported as result 1.
- R10: A start pulse that arrives while busy is ignored. It does not change the running operation's address, function, result or timing, and it does not queue a later operation.
- R11: Done is high for exactly one clock per operation. The result is registered on that clock and holds until the next read completes.
- R12: Cells other than the addressed one never change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| row | input | log2(ROWS) | Selected word line |
| col | input | log2(COLS) | Selected bit line |
| func | input | 4 | Function truth table, bit 2p+q is the result |
| op_p | input | 1 | Operand p |
| op_q | input | 1 | Operand q |
| skip_init | input | 1 | Use the stored cell value as the initial state |
| wl_drv | output | 2*ROWS | Level code per word line, 2 bits each |
| bl_drv | output | 2*COLS | Level code per bit line, 2 bits each |
| result | output | 1 | Last read-out value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Two events can fall in the same clock here. The first is a new start request arriving while an operation is still running, in the preparation pulse, the logic pulse or the read window. The second is the completion pulse of one operation landing on the clock just before the next accepted start. The bench provokes the first by pulsing start, with a different function and address, partway through a running operation. It then judges that the original result and the 204-clock latency are unchanged and that busy stays low afterwards. The second is provoked by issuing requests back to back on the clock after done. Each one is judged by its own read-out, and a later read of a neighbour cell confirms it was not disturbed.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;

    // Level code placed on one array line
    typedef enum logic [1:0] {
        DRV_GND   = 2'd0,
        DRV_HALF  = 2'd1,
        DRV_WRITE = 2'd2,
        DRV_READ  = 2'd3
    } drv_t;

    // Source for one control variable of the assignment
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_P    = 2'd2,
        SRC_Q    = 2'd3
    } src_t;

    typedef struct packed {
        src_t w;
        src_t a;
        src_t b;
        src_t c;
    } asg_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INIT  = 2'd1,
        PH_LOGIC = 2'd2,
        PH_READ  = 2'd3
    } phase_t;

endpackage

// File: rtl/xbar_func_map.sv
`timescale 1ns/1ps
module xbar_func_map
    import xbar_pkg::*;
(
    input  logic [3:0] func,
    input  logic       p,
    input  logic       q,
    output logic       var_w,
    output logic       var_a,
    output logic       var_b,
    output logic       var_c
);

    asg_t asg;

    function automatic logic pick(input src_t s, input logic pv, input logic qv);
        logic v;
        unique case (s)
            SRC_ZERO: v = 1'b0;
            SRC_ONE:  v = 1'b1;
            SRC_P:    v = pv;
            SRC_Q:    v = qv;
        endcase
        return v;
    endfunction

    // Each entry is {W, A, B, C}; the code's bit 2p+q is the result.
    always_comb begin
        unique case (func)
            4'd0:  asg = '{SRC_ZERO, SRC_P,    SRC_P,    SRC_Q};
            4'd1:  asg = '{SRC_ZERO, SRC_Q,    SRC_ONE,  SRC_P};
            4'd2:  asg = '{SRC_ZERO, SRC_Q,    SRC_P,    SRC_ONE};
            4'd3:  asg = '{SRC_ONE,  SRC_P,    SRC_ZERO, SRC_ZERO};
            4'd4:  asg = '{SRC_ZERO, SRC_P,    SRC_Q,    SRC_ONE};
            4'd5:  asg = '{SRC_ONE,  SRC_Q,    SRC_ZERO, SRC_ZERO};
            4'd6:  asg = '{SRC_ZERO, SRC_P,    SRC_Q,    SRC_P};
            4'd7:  asg = '{SRC_ONE,  SRC_ZERO, SRC_P,    SRC_Q};
            4'd8:  asg = '{SRC_ZERO, SRC_P,    SRC_ZERO, SRC_Q};
            4'd9:  asg = '{SRC_ONE,  SRC_P,    SRC_Q,    SRC_Q};
            4'd10: asg = '{SRC_Q,    SRC_P,    SRC_P,    SRC_Q};
            4'd11: asg = '{SRC_ONE,  SRC_Q,    SRC_P,    SRC_ONE};
            4'd12: asg = '{SRC_P,    SRC_P,    SRC_P,    SRC_Q};
            4'd13: asg = '{SRC_ONE,  SRC_P,    SRC_Q,    SRC_ONE};
            4'd14: asg = '{SRC_Q,    SRC_P,    SRC_ZERO, SRC_ONE};
            4'd15: asg = '{SRC_ONE,  SRC_P,    SRC_P,    SRC_Q};
        endcase
    end

    assign var_w = pick(asg.w, p, q);
    assign var_a = pick(asg.a, p, q);
    assign var_b = pick(asg.b, p, q);
    assign var_c = pick(asg.c, p, q);

endmodule

// File: rtl/xbar_line_drv.sv
`timescale 1ns/1ps
module xbar_line_drv
    import xbar_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int RW   = 3,
    parameter int CW   = 3
) (
    input  phase_t              phase,
    input  logic [RW-1:0]       row,
    input  logic [CW-1:0]       col,
    input  logic                wl_hi,
    input  logic                bl_hi,
    output logic [2*ROWS-1:0]   wl_drv,
    output logic [2*COLS-1:0]   bl_drv
);

    for (genvar i = 0; i < ROWS; i++) begin : g_wl
        drv_t code;
        always_comb begin
            unique case (phase)
                PH_IDLE:  code = DRV_GND;
                PH_READ:  code = (row == RW'(i)) ? DRV_READ : DRV_HALF;
                default:  code = (row == RW'(i)) ? (wl_hi ? DRV_WRITE : DRV_GND)
                                                 : DRV_HALF;
            endcase
        end
        assign wl_drv[2*i +: 2] = code;
    end

    for (genvar j = 0; j < COLS; j++) begin : g_bl
        drv_t code;
        always_comb begin
            unique case (phase)
                PH_IDLE:  code = DRV_GND;
                PH_READ:  code = (col == CW'(j)) ? DRV_GND : DRV_HALF;
                default:  code = (col == CW'(j)) ? (bl_hi ? DRV_WRITE : DRV_GND)
                                                 : DRV_HALF;
            endcase
        end
        assign bl_drv[2*j +: 2] = code;
    end

endmodule

// File: rtl/xbar_cell_array.sv
`timescale 1ns/1ps
module xbar_cell_array
    import xbar_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [2*ROWS-1:0]      wl_drv,
    input  logic [2*COLS-1:0]      bl_drv,
    output logic [ROWS*COLS-1:0]   cells
);

    // Every cell reacts only to the full write level across it.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic set_now;
            logic clr_now;
            assign set_now = (wl_drv[2*r +: 2] == DRV_WRITE) && (bl_drv[2*c +: 2] == DRV_GND);
            assign clr_now = (bl_drv[2*c +: 2] == DRV_WRITE) && (wl_drv[2*r +: 2] == DRV_GND);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[r*COLS + c] <= 1'b0;
                end else if (commit && set_now) begin
                    cells[r*COLS + c] <= 1'b1;
                end else if (commit && clr_now) begin
                    cells[r*COLS + c] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/xbar_logic_seq.sv
`timescale 1ns/1ps
module xbar_logic_seq
    import xbar_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int CLK_HZ   = 200_000_000,
    parameter int PULSE_NS = 500,
    parameter int READ_CYC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(ROWS)-1:0]    row,
    input  logic [$clog2(COLS)-1:0]    col,
    input  logic [3:0]                 func,
    input  logic                       op_p,
    input  logic                       op_q,
    input  logic                       skip_init,
    output logic [2*ROWS-1:0]          wl_drv,
    output logic [2*COLS-1:0]          bl_drv,
    output logic                       result,
    output logic                       busy,
    output logic                       done
);

    localparam int RW        = $clog2(ROWS);
    localparam int CW        = $clog2(COLS);
    localparam int IDX_W     = $clog2(ROWS*COLS);
    localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_NS / 1000;
    localparam int CNT_MAX   = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    phase_t             state;
    logic [CNT_W-1:0]   cnt;
    logic [RW-1:0]      lat_row;
    logic [CW-1:0]      lat_col;
    logic [3:0]         lat_func;
    logic               lat_p;
    logic               lat_q;

    logic               pulse_end;
    logic               read_end;
    logic               commit;
    logic               wl_hi;
    logic               bl_hi;
    logic               var_w;
    logic               var_a;
    logic               var_b;
    logic               var_c;
    logic [ROWS*COLS-1:0] cells;
    logic [IDX_W-1:0]   sel_idx;

    assign pulse_end = (cnt == CNT_W'(PULSE_CYC - 1));
    assign read_end  = (cnt == CNT_W'(READ_CYC - 1));
    assign sel_idx   = IDX_W'(lat_row) * IDX_W'(COLS) + IDX_W'(lat_col);

    // State register, phase counter and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            cnt      <= '0;
            lat_row  <= '0;
            lat_col  <= '0;
            lat_func <= '0;
            lat_p    <= 1'b0;
            lat_q    <= 1'b0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (start) begin
                        lat_row  <= row;
                        lat_col  <= col;
                        lat_func <= func;
                        lat_p    <= op_p;
                        lat_q    <= op_q;
                        cnt      <= '0;
                        state    <= skip_init ? PH_LOGIC : PH_INIT;
                    end
                end
                PH_INIT: begin
                    if (pulse_end) begin
                        cnt   <= '0;
                        state <= PH_LOGIC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOGIC: begin
                    if (pulse_end) begin
                        cnt   <= '0;
                        state <= PH_READ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_READ: begin
                    if (read_end) begin
                        cnt   <= '0;
                        state <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Completion pulse and registered read-out
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= 1'b0;
        end else begin
            done <= (state == PH_READ) && read_end;
            if ((state == PH_READ) && read_end) begin
                result <= cells[sel_idx];
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy   = 1'b1;
        commit = 1'b0;
        wl_hi  = 1'b0;
        bl_hi  = 1'b0;
        unique case (state)
            PH_IDLE: begin
                busy = 1'b0;
            end
            PH_INIT: begin
                commit = pulse_end;
                wl_hi  = var_w;
                bl_hi  = !var_w;
            end
            PH_LOGIC: begin
                commit = pulse_end;
                wl_hi  = var_c ? var_a : var_b;
                bl_hi  = var_c ? var_b : var_a;
            end
            PH_READ: begin
                commit = 1'b0;
            end
        endcase
    end

    xbar_func_map u_map (
        .func  (lat_func),
        .p     (lat_p),
        .q     (lat_q),
        .var_w (var_w),
        .var_a (var_a),
        .var_b (var_b),
        .var_c (var_c)
    );

    xbar_line_drv #(
        .ROWS (ROWS),
        .COLS (COLS),
        .RW   (RW),
        .CW   (CW)
    ) u_drv (
        .phase  (state),
        .row    (lat_row),
        .col    (lat_col),
        .wl_hi  (wl_hi),
        .bl_hi  (bl_hi),
        .wl_drv (wl_drv),
        .bl_drv (bl_drv)
    );

    xbar_cell_array #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .wl_drv (wl_drv),
        .bl_drv (bl_drv),
        .cells  (cells)
    );

endmodule

// File: rtl/xbar_logic_seq_chk.sv
`timescale 1ns/1ps
module xbar_logic_seq_chk
    import xbar_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              busy,
    input  logic                              done,
    input  logic [2*ROWS-1:0]                 wl_drv,
    input  logic [2*COLS-1:0]                 bl_drv,
    input  logic [$clog2(ROWS)-1:0]           lat_row,
    input  logic [$clog2(COLS)-1:0]           lat_col,
    input  logic [3:0]                        lat_func,
    input  logic [$clog2(ROWS*COLS)-1:0]      sel_idx,
    input  logic [ROWS*COLS-1:0]              cells
);

    logic [ROWS-1:0]      wl_not_half;
    logic [COLS-1:0]      bl_not_half;
    logic [ROWS*COLS-1:0] sel_mask;

    always_comb begin
        for (int i = 0; i < ROWS; i++) wl_not_half[i] = (wl_drv[2*i +: 2] != DRV_HALF);
        for (int j = 0; j < COLS; j++) bl_not_half[j] = (bl_drv[2*j +: 2] != DRV_HALF);
        sel_mask = '0;
        sel_mask[sel_idx] = 1'b1;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    idle_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wl_drv == '0) && (bl_drv == '0));

    // R6
    half_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(wl_not_half) <= 1) && ($countones(bl_not_half) <= 1));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_row) && $stable(lat_col) && $stable(lat_func)));

    // R12
    no_disturb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (((cells ^ $past(cells)) & ~$past(sel_mask)) == '0));

endmodule

bind xbar_logic_seq xbar_logic_seq_chk #(
    .ROWS (ROWS),
    .COLS (COLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .wl_drv   (wl_drv),
    .bl_drv   (bl_drv),
    .lat_row  (lat_row),
    .lat_col  (lat_col),
    .lat_func (lat_func),
    .sel_idx  (sel_idx),
    .cells    (cells)
);

// File: tb/xbar_logic_seq_bench.sv
`timescale 1ns/1ps
module xbar_logic_seq_bench;

    localparam int FULL_LAT = 204;
    localparam int SKIP_LAT = 104;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  row = '0;
    logic [2:0]  col = '0;
    logic [3:0]  func = '0;
    logic        op_p = 1'b0;
    logic        op_q = 1'b0;
    logic        skip_init = 1'b0;
    logic [15:0] wl_drv;
    logic [15:0] bl_drv;
    logic        result;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] sa_wl, sa_bl, sb_wl, sb_bl, sc_wl, sc_bl;

    always #2.5 clk = ~clk;

    xbar_logic_seq u_xbar_logic_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .row       (row),
        .col       (col),
        .func      (func),
        .op_p      (op_p),
        .op_q      (op_q),
        .skip_init (skip_init),
        .wl_drv    (wl_drv),
        .bl_drv    (bl_drv),
        .result    (result),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lv(input logic [15:0] v, input int i);
        return int'(v[2*i +: 2]);
    endfunction

    task automatic run_op(input logic [3:0] f, input logic p, input logic q,
                          input int r, input int c, input logic sk, input bit poke,
                          output logic res, output int lat);
        int n;
        @(negedge clk);
        func = f; op_p = p; op_q = q; row = 3'(r); col = 3'(c);
        skip_init = sk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 2000) begin
            if (n == 50)  begin sa_wl = wl_drv; sa_bl = bl_drv; end
            if (n == 150) begin sb_wl = wl_drv; sb_bl = bl_drv; end
            if (n == 202) begin sc_wl = wl_drv; sc_bl = bl_drv; end
            if (poke && n == 30) begin
                start = 1'b1; func = ~f; row = 3'(r + 1); col = 3'(c + 2);
            end
            if (poke && n == 31) start = 1'b0;
            @(negedge clk);
            n++;
        end
        if (!done) chk(1'b0, "watchdog per-op (R2)", n, FULL_LAT);
        res = result;
        lat = n - 1;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(result == 1'b0, "R1 result", result, 0);
        chk(wl_drv == '0 && bl_drv == '0, "R1 lines", int'(wl_drv | bl_drv), 0);
    endtask

    task automatic t_truth();
        logic res;
        int lat;
        for (int f = 0; f < 16; f++) begin
            for (int pq = 0; pq < 4; pq++) begin
                logic [3:0] fc;
                fc = 4'(f);
                run_op(fc, pq[1], pq[0], f % 8, (f + pq) % 8, 1'b0, 1'b0, res, lat);
                chk(res == fc[pq], $sformatf("R7 code %0d p%0d q%0d", f, pq[1], pq[0]),
                    res, fc[pq]);
            end
        end
    endtask

    task automatic t_drive();
        logic res;
        int lat;
        run_op(4'd15, 1'b0, 1'b0, 2, 5, 1'b0, 1'b0, res, lat);
        chk(lv(sa_wl, 2) == 2, "R3 W=1 wl write", lv(sa_wl, 2), 2);
        chk(lv(sa_bl, 5) == 0, "R3 W=1 bl ground", lv(sa_bl, 5), 0);
        chk(lv(sa_wl, 0) == 1 && lv(sa_bl, 0) == 1, "R6 unselected half", lv(sa_wl, 0), 1);
        chk(lv(sc_wl, 2) == 3, "R9 read wl level", lv(sc_wl, 2), 3);
        chk(lv(sc_bl, 5) == 0, "R9 read bl ground", lv(sc_bl, 5), 0);
        chk(lv(sc_wl, 7) == 1, "R6 read unselected half", lv(sc_wl, 7), 1);
        chk(lat == FULL_LAT, "R2 full latency", lat, FULL_LAT);
        chk(res == 1'b1, "R9 stored one reads one", res, 1);
        run_op(4'd0, 1'b1, 1'b0, 1, 1, 1'b0, 1'b0, res, lat);
        chk(lv(sa_wl, 1) == 0 && lv(sa_bl, 1) == 2, "R3 W=0 bl write", lv(sa_bl, 1), 2);
        run_op(4'd8, 1'b1, 1'b1, 3, 4, 1'b0, 1'b0, res, lat);
        chk(lv(sb_wl, 3) == 2 && lv(sb_bl, 4) == 0, "R4 C=1 A on wl", lv(sb_wl, 3), 2);
        chk(res == 1'b1, "R5 wl high bl low sets", res, 1);
        run_op(4'd8, 1'b1, 1'b0, 3, 4, 1'b0, 1'b0, res, lat);
        chk(lv(sb_wl, 3) == 0 && lv(sb_bl, 4) == 2, "R4 C=0 A on bl", lv(sb_bl, 4), 2);
        chk(res == 1'b0, "R5 bl high keeps zero", res, 0);
    endtask

    task automatic t_skip();
        logic res;
        int lat;
        run_op(4'd15, 1'b0, 1'b0, 6, 6, 1'b0, 1'b0, res, lat);
        run_op(4'd0, 1'b1, 1'b1, 6, 6, 1'b1, 1'b0, res, lat);
        chk(res == 1'b1, "R8 skip keeps stored one", res, 1);
        chk(lat == SKIP_LAT, "R8 skip latency", lat, SKIP_LAT);
        run_op(4'd0, 1'b0, 1'b0, 6, 6, 1'b0, 1'b0, res, lat);
        run_op(4'd0, 1'b0, 1'b1, 6, 6, 1'b1, 1'b0, res, lat);
        chk(res == 1'b0, "R8 skip keeps stored zero", res, 0);
    endtask

    task automatic t_busy_start();
        logic res;
        int lat;
        run_op(4'd7, 1'b1, 1'b1, 0, 0, 1'b0, 1'b1, res, lat);
        chk(res == 1'b0, "R10 result of original op", res, 0);
        chk(lat == FULL_LAT, "R10 latency unchanged", lat, FULL_LAT);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R10 no queued op", busy, 0);
        end
    endtask

    task automatic t_done();
        logic res;
        int lat;
        run_op(4'd14, 1'b1, 1'b0, 5, 2, 1'b0, 1'b0, res, lat);
        chk(res == 1'b1, "R11 result at done", res, 1);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        chk(result == 1'b1, "R11 result held", result, 1);
        repeat (5) @(negedge clk);
        chk(result == 1'b1, "R11 result held idle", result, 1);
    endtask

    task automatic t_disturb();
        logic res;
        int lat;
        run_op(4'd15, 1'b0, 1'b0, 2, 3, 1'b0, 1'b0, res, lat);
        run_op(4'd0, 1'b0, 1'b0, 2, 5, 1'b0, 1'b0, res, lat);
        run_op(4'd0, 1'b0, 1'b0, 4, 3, 1'b0, 1'b0, res, lat);
        run_op(4'd15, 1'b1, 1'b1, 4, 5, 1'b0, 1'b0, res, lat);
        run_op(4'd0, 1'b0, 1'b0, 2, 3, 1'b1, 1'b0, res, lat);
        chk(res == 1'b1, "R12 neighbour cell kept one", res, 1);
        run_op(4'd0, 1'b0, 1'b0, 2, 5, 1'b1, 1'b0, res, lat);
        chk(res == 1'b0, "R12 neighbour cell kept zero", res, 0);
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_truth();
        t_skip();
        t_busy_start();
        t_done();
        t_disturb();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule